// File: doc/BRIEF.md
# Float32 Normalize and Round Unit

This block is the final packing stage of a single-precision arithmetic datapath. An upstream operator (adder, multiplier, divider) hands it an unpacked result: a sign, a signed biased exponent that may lie far outside the representable range, and a 32-bit working significand carrying extra bits below the final mantissa. The block normalizes the significand and pushes tiny results into the subnormal range with sticky jamming. It then rounds under one of four modes and detects overflow and underflow. It returns the IEEE-754 binary32 word along with the accumulated exception flags.

Infinity and NaN operands (exponent 255) and zero significands skip the rounding path and are packed directly. All other values pass through one combinational path: normalize, jam, round, range check. The result lands in an output register one clock after a valid input is presented.

Top module: `fnr_pack_core`

## Requirements
- R1: When exp_i equals 255 the result is {sign_i, 8'hFF, sig_i[29:7]} and flags_o equals flags_i.
- R2: When exp_i is not 255 and sig_i is zero the result is a zero carrying sign_i (all bits but bit 31 clear) and flags_o equals flags_i.
- R3: An operand represents (-1)^sign_i * sig_i * 2^(exp_i - 157), where exp_i is a two's-complement value. A nonzero significand with its leading one at any position packs to the correctly rounded binary32 encoding of that value.
- R4: When the normalized exponent is negative the significand is shifted right into the subnormal range, and every bit shifted out is ORed into the lowest bit. A shift of 32 or more leaves only that sticky bit.
- R5: Mode 2'b00 rounds to nearest with ties to even.
- R6: Mode 2'b11 rounds toward zero (truncates).
- R7: Mode 2'b01 rounds toward +infinity and mode 2'b10 toward -infinity: the magnitude is bumped for positive values under 01 and for negative values under 10, and truncated otherwise.
- R8: A rounding carry out of the significand raises the exponent by one (e.g. a mantissa of all ones rounds up to the next power of two).
- R9: Flag bit 0 (inexact) is set when any of the 8 bits below the result LSB are nonzero before rounding, and on every overflow.
- R10: When the rounded exponent field would reach 255 the block sets flag bit 1 (overflow) and bit 0 (inexact). It returns the largest finite magnitude 0x7F7FFFFF when the mode truncates that sign, and infinity 0x7F800000 otherwise, with sign_i in bit 31.
- R11: Flag bit 2 (underflow) is set only for a value that was jammed into the subnormal range, was inexact after jamming, and after rounding still has exponent field 0 or is exactly the smallest normal.
- R12: flags_o is flags_i ORed with the newly raised flags; input flags are never cleared.
- R13: valid_o follows valid_i with one cycle of latency; reset clears valid_o, result_o and flags_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand valid |
| sign_i | input | 1 | Sign of the operand |
| exp_i | input | EXP_W | Signed biased exponent |
| sig_i | input | 32 | Working significand with guard bits |
| rmode_i | input | 2 | Rounding mode: 00 nearest, 01 +inf, 10 -inf, 11 toward zero |
| flags_i | input | 3 | Pending flags: bit 0 inexact, bit 1 overflow, bit 2 underflow |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Packed binary32 result |
| flags_o | output | 3 | Accumulated flags, same bit order as flags_i |

## Verification
The bench builds the block with EXP_W = 10, so exponents span -512 to 511. That range is wide enough to drive operands far past both ends of the binary32 range. Exponents below about -300 force a jam shift of more than 32 bits, which leaves only the sticky bit. Exponents in the hundreds push the rounded field past 254 under every rounding mode and sign. A behavioural model in the bench predicts each output word and flag set on every clock, across directed ties, carries and boundaries and a randomized sweep.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  localparam int SIG_W   = 32;
  localparam int LOW_W   = 8;              // bits below the result LSB
  localparam int FRAC_W  = 23;
  localparam int BEXP_W  = 8;
  localparam int EXP_SPEC = 255;
  localparam int EXP_OVF  = 254;
  localparam int FLG_W   = 3;
  localparam int FLG_INX = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;

  localparam logic [30:0] MAG_MAXF = 31'h7F7F_FFFF;
  localparam logic [30:0] MAG_INF  = 31'h7F80_0000;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_PINF = 2'b01,
    RND_NINF = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fnr_lzc.sv
module fnr_lzc #(
  parameter int W = 32
) (
  input  logic [W-1:0]         vec_i,
  output logic [$clog2(W):0]   cnt_o
);
  localparam int CW = $clog2(W) + 1;

  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fnr_jam_shift.sv
module fnr_jam_shift #(
  parameter int W     = 32,
  parameter int AMT_W = 11
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     data_o
);
  localparam int ST = $clog2(W);

  logic [W-1:0] stg [ST+1];
  logic         big;

  assign stg[0] = data_i;

  // log shifter; each stage folds its lost bits into bit 0
  for (genvar s = 0; s < ST; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? ((stg[s] >> SH) | W'(|stg[s][SH-1:0]))
                               : stg[s];
  end

  assign big    = |amt_i[AMT_W-1:ST];
  assign data_o = big ? W'(|data_i) : stg[ST];
endmodule

// File: rtl/fnr_round.sv
module fnr_round
  import fnr_pkg::*;
#(
  parameter int XW = 11
) (
  input  logic              sign_i,
  input  logic [XW-1:0]     exp_i,    // non-negative here
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              tiny_i,
  input  logic [1:0]        rmode_i,
  output logic [30:0]       mag_o,
  output logic              inx_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [LOW_W-1:0] incr;
  logic [SIG_W:0]   sum;
  logic             carry;
  logic [SIG_W-1:0] sig_pre;
  logic [SIG_W-1:0] sig_r;
  logic [XW:0]      exp_r;
  logic             low_nz;
  logic [30:0]      mag_norm;

  always_comb begin
    unique case (rnd_mode_e'(rmode_i))
      RND_NEAR: incr = sig_i[LOW_W] ? LOW_W'(1 << (LOW_W-1)) : LOW_W'((1 << (LOW_W-1)) - 1);
      RND_ZERO: incr = '0;
      RND_PINF: incr = sign_i ? '0 : '1;
      RND_NINF: incr = sign_i ? '1 : '0;
      default:  incr = '0;
    endcase
  end

  assign sum     = {1'b0, sig_i} + (SIG_W+1)'(incr);
  assign carry   = sum[SIG_W];
  assign sig_pre = carry ? ((sig_i >> 1) | SIG_W'(sig_i[0])) : sig_i;
  assign exp_r   = {1'b0, exp_i} + (XW+1)'(carry);
  assign sig_r   = sig_pre + SIG_W'(incr);
  assign low_nz  = |sig_pre[LOW_W-1:0];

  assign ovf_o    = exp_r >= (XW+1)'(EXP_OVF);
  assign mag_norm = {exp_r[BEXP_W-1:0], {FRAC_W{1'b0}}} + 31'(sig_r >> LOW_W);

  assign mag_o = ovf_o ? ((incr == '0) ? MAG_MAXF : MAG_INF) : mag_norm;
  assign inx_o = low_nz | ovf_o;
  assign unf_o = tiny_i && (|sig_i[LOW_W-1:0]) && (exp_r == '0)
               && (sig_r <= 32'h8000_0000);
endmodule

// File: rtl/fnr_pack_core.sv
module fnr_pack_core
  import fnr_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [31:0]             sig_i,
  input  logic [1:0]              rmode_i,
  input  logic [2:0]              flags_i,
  output logic                    valid_o,
  output logic [31:0]             result_o,
  output logic [2:0]              flags_o
);
  localparam int XW  = EXP_W + 1;
  localparam int LZW = $clog2(SIG_W) + 1;

  logic [LZW-1:0]       lz;
  logic [SIG_W-1:0]     sig_nrm;
  logic signed [XW-1:0] exp_nrm;
  logic                 tiny;
  logic [XW-1:0]        amt;
  logic [SIG_W-1:0]     sig_jam;
  logic [SIG_W-1:0]     sig_rd;
  logic [XW-1:0]        exp_rd;
  logic [30:0]          mag;
  logic                 inx, ovf, unf;
  logic                 is_spec, is_zero;
  logic [31:0]          res_d;
  logic [FLG_W-1:0]     flg_d, flg_new;

  fnr_lzc #(.W(SIG_W)) u_lzc (
    .vec_i (sig_i),
    .cnt_o (lz)
  );

  assign sig_nrm = sig_i << lz;
  assign exp_nrm = XW'(exp_i) - XW'(lz);
  assign tiny    = exp_nrm[XW-1];
  assign amt     = -exp_nrm;

  fnr_jam_shift #(.W(SIG_W), .AMT_W(XW)) u_jam (
    .data_i (sig_nrm),
    .amt_i  (amt),
    .data_o (sig_jam)
  );

  assign sig_rd = tiny ? sig_jam : sig_nrm;
  assign exp_rd = tiny ? '0 : exp_nrm;

  fnr_round #(.XW(XW)) u_round (
    .sign_i  (sign_i),
    .exp_i   (exp_rd),
    .sig_i   (sig_rd),
    .tiny_i  (tiny),
    .rmode_i (rmode_i),
    .mag_o   (mag),
    .inx_o   (inx),
    .ovf_o   (ovf),
    .unf_o   (unf)
  );

  assign is_spec = exp_i == EXP_W'(EXP_SPEC);
  assign is_zero = sig_i == '0;

  always_comb begin
    flg_new          = '0;
    flg_new[FLG_INX] = inx;
    flg_new[FLG_OVF] = ovf;
    flg_new[FLG_UNF] = unf;
    if (is_spec) begin
      res_d = {sign_i, 8'hFF, sig_i[29:7]};
      flg_d = flags_i;
    end else if (is_zero) begin
      res_d = {sign_i, 31'b0};
      flg_d = flags_i;
    end else begin
      res_d = {sign_i, mag};
      flg_d = flags_i | flg_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flg_d;
      end
    end
  end
endmodule

// File: rtl/fnr_pack_core_chk.sv
module fnr_pack_core_chk #(
  parameter int EXP_W = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    sign_i,
  input logic signed [EXP_W-1:0] exp_i,
  input logic [31:0]             sig_i,
  input logic [2:0]              flags_i,
  input logic                    valid_o,
  input logic [31:0]             result_o,
  input logic [2:0]              flags_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_valid_follow_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  assert_flags_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i)) |-> ((flags_o & $past(flags_i)) == $past(flags_i)));

  assert_zero_signed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && $past(sig_i) == 32'h0 && $past(exp_i) != EXP_W'(255))
      |-> (result_o[30:0] == 31'h0 && result_o[31] == $past(sign_i)));

  assert_inf_needs_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && $past(exp_i) != EXP_W'(255) && result_o[30:23] == 8'hFF)
      |-> (flags_o[1] && result_o[22:0] == 23'h0));

  assert_ovf_inexact_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && flags_o[1] && !$past(flags_i[1])) |-> flags_o[0]);

  assert_unf_tiny_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && flags_o[2] && !$past(flags_i[2]))
      |-> (flags_o[0] && result_o[30:23] <= 8'd1));
endmodule

bind fnr_pack_core fnr_pack_core_chk #(.EXP_W(EXP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .sign_i   (sign_i),
  .exp_i    (exp_i),
  .sig_i    (sig_i),
  .flags_i  (flags_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/tb_fnr_pack_core.sv
module tb_fnr_pack_core;
  localparam int CLK_P = 10;
  localparam int EXP_W = 10;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    valid_i = 1'b0;
  logic                    sign_i = 1'b0;
  logic signed [EXP_W-1:0] exp_i = '0;
  logic [31:0]             sig_i = '0;
  logic [1:0]              rmode_i = '0;
  logic [2:0]              flags_i = '0;
  logic                    valid_o;
  logic [31:0]             result_o;
  logic [2:0]              flags_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R13";

  always #(CLK_P/2) clk = ~clk;

  fnr_pack_core #(.EXP_W(EXP_W)) dut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i), .sign_i (sign_i),
    .exp_i (exp_i), .sig_i (sig_i), .rmode_i (rmode_i), .flags_i (flags_i),
    .valid_o (valid_o), .result_o (result_o), .flags_o (flags_o)
  );

  // behavioural reference: value = (-1)^s * m * 2^(e-157)
  function automatic void ref_pack(input bit s, input int e, input bit [31:0] m,
                                   input bit [1:0] rm, input bit [2:0] fi,
                                   output bit [31:0] r, output bit [2:0] fo);
    longint ex;
    bit [31:0] g;
    bit tiny, tiny_inx, inx, unf;
    int incr;
    longint sum;
    bit [31:0] mag;
    if (e == 255) begin r = {s, 8'hFF, m[29:7]}; fo = fi; return; end
    if (m == 0)   begin r = {s, 31'b0};          fo = fi; return; end
    ex = e; g = m;
    while (!g[31]) begin g = g << 1; ex = ex - 1; end
    tiny = ex < 0;
    if (tiny) begin
      for (longint k = 0; k < -ex; k++) g = (g >> 1) | {31'b0, g[0]};
      ex = 0;
    end
    tiny_inx = |g[7:0];
    case (rm)
      2'b00: incr = g[8] ? 128 : 127;
      2'b01: incr = s ? 0 : 255;
      2'b10: incr = s ? 255 : 0;
      default: incr = 0;
    endcase
    sum = longint'(g) + incr;
    if (sum >= 64'h1_0000_0000) begin ex = ex + 1; g = (g >> 1) | {31'b0, g[0]}; end
    inx = |g[7:0];
    g = g + 32'(incr);
    if (ex >= 254) begin
      fo = fi | 3'b011;
      r  = {s, (incr == 0) ? 31'h7F7F_FFFF : 31'h7F80_0000};
    end else begin
      mag = 32'(ex << 23) + (g >> 8);
      unf = tiny && tiny_inx && ex == 0 && g <= 32'h8000_0000;
      fo  = fi | {unf, 1'b0, inx};
      r   = {s, mag[30:0]};
    end
  endfunction

  // per-clock comparison against the reference
  bit        m_v;
  bit [31:0] m_r;
  bit [2:0]  m_f;
  string     m_tag;
  always @(posedge clk) begin
    if (rst_n && !done) begin
      m_v   = valid_i;
      m_tag = cur_tag;
      ref_pack(sign_i, int'(exp_i), sig_i, rmode_i, flags_i, m_r, m_f);
      #(CLK_P/4);
      n_chk++;
      if (valid_o !== m_v) begin
        n_fail++;
        $display("FAIL %s valid_o act=%b exp=%b", m_tag, valid_o, m_v);
      end else if (m_v && (result_o !== m_r || flags_o !== m_f)) begin
        n_fail++;
        $display("FAIL %s result act=%h/%b exp=%h/%b", m_tag, result_o, flags_o, m_r, m_f);
      end
    end
  end

  task automatic chk_lit(input string tag, input bit [31:0] er, input bit [2:0] ef);
    n_chk++;
    if (result_o !== er || flags_o !== ef) begin
      n_fail++;
      $display("FAIL %s literal act=%h/%b exp=%h/%b", tag, result_o, flags_o, er, ef);
    end
  endtask

  task automatic apply(input string tag, input bit s, input int e, input bit [31:0] m,
                       input bit [1:0] rm, input bit [2:0] f);
    @(negedge clk);
    cur_tag = tag;
    valid_i = 1'b1; sign_i = s; exp_i = EXP_W'(e); sig_i = m; rmode_i = rm; flags_i = f;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R13 reset state
    if (valid_o !== 1'b0 || result_o !== 32'h0 || flags_o !== 3'b0) begin
      n_fail++;
      $display("FAIL R13 reset act=%b/%h/%b exp=0/0/0", valid_o, result_o, flags_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    apply("R3", 0, 127, 32'h4000_0000, 2'b00, 3'b000); chk_lit("R3", 32'h3F80_0000, 3'b000);
    apply("R3", 0, 157, 32'h0000_0001, 2'b00, 3'b000); chk_lit("R3", 32'h3F80_0000, 3'b000);
    apply("R1", 1, 255, 32'h0000_0000, 2'b00, 3'b100); chk_lit("R1", 32'hFF80_0000, 3'b100);
    apply("R1", 0, 255, 32'h2000_0000, 2'b01, 3'b000); chk_lit("R1", 32'h7FC0_0000, 3'b000);
    apply("R2", 1, 5, 32'h0, 2'b10, 3'b010);           chk_lit("R2", 32'h8000_0000, 3'b010);
    apply("R5", 0, 127, 32'h4000_0040, 2'b00, 3'b000); chk_lit("R5", 32'h3F80_0000, 3'b001);
    apply("R5", 0, 127, 32'h4000_00C0, 2'b00, 3'b000); chk_lit("R5", 32'h3F80_0002, 3'b001);
    apply("R8", 0, 127, 32'h7FFF_FFFF, 2'b00, 3'b000); chk_lit("R8", 32'h4000_0000, 3'b001);
    apply("R6", 1, 127, 32'h7FFF_FFFF, 2'b11, 3'b000); chk_lit("R6", 32'hBFFF_FFFF, 3'b001);

    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        apply("R7", sg[0], 130, 32'h4123_4567, md[1:0], 3'b000);
        apply("R9", sg[0], 100, 32'h4000_0100, md[1:0], 3'b000);
        apply("R10", sg[0], 400, 32'h4000_0000, md[1:0], 3'b000);
        apply("R10", sg[0], 254, 32'h7FFF_FFFF, md[1:0], 3'b000);
        apply("R4", sg[0], -300, 32'h4000_0000, md[1:0], 3'b000);
        apply("R11", sg[0], -5, 32'h4567_89AB, md[1:0], 3'b000);
        apply("R11", sg[0], 0, 32'h7FFF_FFF0, md[1:0], 3'b000);
      end
    end
    apply("R10", 0, 400, 32'h4000_0000, 2'b11, 3'b000); chk_lit("R10", 32'h7F7F_FFFF, 3'b011);
    apply("R10", 1, 400, 32'h4000_0000, 2'b00, 3'b000); chk_lit("R10", 32'hFF80_0000, 3'b011);
    apply("R4", 0, -300, 32'h4000_0000, 2'b01, 3'b000); chk_lit("R4", 32'h0000_0001, 3'b101);
    apply("R11", 0, 0, 32'h4000_0000, 2'b00, 3'b000);   chk_lit("R11", 32'h0040_0000, 3'b000);
    apply("R12", 0, 127, 32'h4000_0000, 2'b00, 3'b110); chk_lit("R12", 32'h3F80_0000, 3'b110);

    for (int i = 0; i < 300; i++) begin
      apply("R3", 1'($urandom), int'($urandom_range(700)) - 300,
            $urandom >> $urandom_range(31), 2'($urandom), 3'($urandom));
    end

    @(negedge clk);
    cur_tag = "R13";
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    #(CLK_P);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule